// File: doc/BRIEF.md
# I2C Message Sequencer

This block carries out one complete I2C master message without help from a processor for each byte. It sits beside a byte-level master core that reports progress through a flag and an 8-bit status code. Each time the flag rises, the sequencer reads the code and picks the next action. It then writes the core's data register, its control register, or both. A write to the control register acknowledges the flag.

The caller supplies the target address, a 10-bit addressing flag, the direction, a flag to skip the start and address phases, and a byte count. It then pulses `start`. Bytes to transmit come in on a valid/ready stream, and received bytes leave on a second valid/ready stream. When the message ends, the block gives a one-cycle `done`, which may come with a no-device error or a timeout error. A programmable cycle limit guards against a core that stops reporting.

Top module: `i2c_msg_seq`

## Requirements
- R1: After reset no core write is issued, `done` and both error outputs are 0, and neither stream handshake is offered.
- R2: The control register bits are ACK at bit 2, STOP at bit 4, START at bit 5, enable at bit 6 and interrupt-enable at bit 7. On status 0x08 or 0x10 the block writes the first address byte with control 0xC4. In 7-bit mode that byte is `{addr[6:0], dir}`, where dir=1 means read.
- R3: In 10-bit mode the first address byte is `0xF0 | addr[9:8]<<1 | dir`. On status 0x18 or 0x40, the second byte `addr[7:0]` is written.
- R4: On a write-side acknowledge, the block sends the next stream byte and counts it down. The write-side acknowledges are 0x18 in 7-bit mode, 0xD0 and 0x28. Once the count is exhausted, the next acknowledge writes STOP and pulses `done`.
- R5: On a read, each received byte is offered on the read stream. Status 0x50 delivers a byte, and status 0x58 delivers the last byte, writes STOP and pulses `done`. The control write that comes before the final byte has ACK cleared (0xC0).
- R6: A read with a byte count of zero writes STOP and finishes at the address acknowledge (0x40 in 7-bit mode, 0xE0 in 10-bit mode).
- R7: Status 0x20, 0x30 or 0x48 writes STOP, pulses `done` and sets `err_nodev`.
- R8: Any status that the current step does not expect writes STOP and pulses `done`, and no error is raised.
- R9: With the skip flag set, `start` leads straight to the data phase. A read issues a bare control write and no data write. A write sends the first stream byte at once.
- R10: If `tmo_limit` is nonzero and no core event arrives for that many cycles, the block enters an abort state. The next flag then writes STOP, pulses `done` and sets `err_timeout`.
- R11: A start request writes control 0xE4. Every STOP write clears interrupt-enable, and every other control write keeps enable and interrupt-enable set.
- R12: A data send waits until the write stream is valid. No core write is issued while it waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that launches a message when the block is idle |
| msg_addr | input | 10 | Target address |
| msg_ten | input | 1 | Use 10-bit addressing |
| msg_read | input | 1 | 1 = read, 0 = write |
| msg_nostart | input | 1 | Skip the start and address phases |
| msg_len | input | LEN_W | Byte count |
| tmo_limit | input | TMO_W | Idle-cycle limit; 0 disables the timeout |
| wr_data | input | 8 | Transmit byte |
| wr_valid | input | 1 | Transmit byte present |
| wr_ready | output | 1 | Transmit byte taken in this cycle |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | Received byte offered |
| rd_ready | input | 1 | Receiver accepts the byte |
| core_flag | input | 1 | Core event flag |
| core_status | input | 8 | Core status code |
| core_rdata | input | 8 | Core receive data register |
| core_wdata | output | 8 | Value for the core data register |
| core_data_we | output | 1 | Core data register write strobe |
| core_ctrl | output | 8 | Value for the core control register |
| core_ctrl_we | output | 1 | Core control register write strobe |
| done | output | 1 | One-cycle end-of-message pulse |
| err_nodev | output | 1 | The target did not acknowledge |
| err_timeout | output | 1 | The message was aborted by the timeout |

## Verification
The bench drives status sequences for 7-bit and 10-bit writes and reads. The two address modes are told apart by the bytes placed in the data register. Comparing reads of one and two bytes shows in which control write the ACK bit is dropped. The bench also covers a zero-length read, NACK codes at the address and data steps, an unknown code and both skip-start directions. Each of these separates a finish with or without an error from a continued message. A stalled write stream and a silent core show that waits issue no writes and that the abort path still ends with STOP.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE, S_WSTART, S_WADDR1, S_WADDR2, S_WSACK, S_WSDATA, S_ABORT
    } seq_state_e;

    typedef enum logic [3:0] {
        A_NONE, A_CONT, A_START, A_ADDR1, A_ADDR2,
        A_DATA, A_RECV, A_RECV_STOP, A_STOP
    } seq_act_e;

    localparam int unsigned CB_ACK   = 2;
    localparam int unsigned CB_STOP  = 4;
    localparam int unsigned CB_START = 5;
    localparam int unsigned CB_EN    = 6;
    localparam int unsigned CB_IE    = 7;

    localparam logic [7:0] ST_START    = 8'h08;
    localparam logic [7:0] ST_RSTART   = 8'h10;
    localparam logic [7:0] ST_WA_ACK   = 8'h18;
    localparam logic [7:0] ST_WA_NACK  = 8'h20;
    localparam logic [7:0] ST_WD_ACK   = 8'h28;
    localparam logic [7:0] ST_WD_NACK  = 8'h30;
    localparam logic [7:0] ST_RA_ACK   = 8'h40;
    localparam logic [7:0] ST_RA_NACK  = 8'h48;
    localparam logic [7:0] ST_RD_ACK   = 8'h50;
    localparam logic [7:0] ST_RD_NACK  = 8'h58;
    localparam logic [7:0] ST_WA2_ACK  = 8'hD0;
    localparam logic [7:0] ST_RA2_ACK  = 8'hE0;

    typedef struct packed {
        seq_act_e   act;
        seq_state_e nxt;
        logic       dec;
        logic       ack_clr;
        logic       nodev;
        logic       finish;
        logic       tmo;
    } seq_dec_t;

    function automatic logic [7:0] first_addr_byte(input logic [9:0] a,
                                                   input logic ten, input logic rd);
        if (ten) return 8'hF0 | {5'b0, a[9:8], 1'b0} | {7'b0, rd};
        return {a[6:0], rd};
    endfunction

    function automatic logic [7:0] ctrl_word(input logic ack, input logic sta,
                                             input logic sto);
        logic [7:0] w;
        w = '0;
        w[CB_EN]    = 1'b1;
        w[CB_IE]    = ~sto;
        w[CB_ACK]   = ack;
        w[CB_START] = sta;
        w[CB_STOP]  = sto;
        return w;
    endfunction

endpackage

// File: rtl/i2c_seq_decide.sv
module i2c_seq_decide
    import i2c_seq_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  seq_state_e       state,
    input  logic             kick,
    input  logic [7:0]       status,
    input  logic             ten,
    input  logic             rd,
    input  logic             nostart,
    input  logic [LEN_W-1:0] left,
    output seq_dec_t         dec
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);
    localparam logic [LEN_W-1:0] TWO = LEN_W'(2);

    seq_dec_t stop_fin, wr_ack, rd_addr, to_a2;
    logic     empty;

    always_comb begin
        empty    = (left == '0);
        stop_fin = '{act: A_STOP, nxt: S_IDLE, dec: 1'b0, ack_clr: 1'b0,
                     nodev: 1'b0, finish: 1'b1, tmo: 1'b0};
        to_a2    = '{act: A_ADDR2, nxt: S_WADDR2, dec: 1'b0, ack_clr: 1'b0,
                     nodev: 1'b0, finish: 1'b0, tmo: 1'b0};
        wr_ack   = empty ? stop_fin :
                   '{act: A_DATA, nxt: S_WSACK, dec: 1'b1, ack_clr: 1'b0,
                     nodev: 1'b0, finish: 1'b0, tmo: 1'b0};
        rd_addr  = empty ? stop_fin :
                   '{act: A_CONT, nxt: S_WSDATA, dec: 1'b0, ack_clr: (left == ONE),
                     nodev: 1'b0, finish: 1'b0, tmo: 1'b0};

        dec = stop_fin;
        if (kick) begin
            if (!nostart)
                dec = '{act: A_START, nxt: S_WSTART, dec: 1'b0, ack_clr: 1'b0,
                        nodev: 1'b0, finish: 1'b0, tmo: 1'b0};
            else if (rd)
                dec = rd_addr;
            else
                dec = wr_ack;
        end else if (state == S_IDLE) begin
            dec.finish = 1'b0;
        end else if (state == S_ABORT) begin
            dec.tmo = 1'b1;
        end else begin
            case (status)
                ST_START, ST_RSTART:
                    dec = '{act: A_ADDR1, nxt: S_WADDR1, dec: 1'b0, ack_clr: 1'b0,
                            nodev: 1'b0, finish: 1'b0, tmo: 1'b0};
                ST_WA_ACK:  dec = ten ? to_a2 : wr_ack;
                ST_WA2_ACK, ST_WD_ACK: dec = wr_ack;
                ST_RA_ACK:  dec = ten ? to_a2 : rd_addr;
                ST_RA2_ACK: dec = rd_addr;
                ST_RD_ACK:
                    dec = '{act: A_RECV, nxt: S_WSDATA, dec: !empty,
                            ack_clr: (left == TWO), nodev: 1'b0, finish: 1'b0,
                            tmo: 1'b0};
                ST_RD_NACK:
                    dec = '{act: A_RECV_STOP, nxt: S_IDLE, dec: !empty, ack_clr: 1'b0,
                            nodev: 1'b0, finish: 1'b1, tmo: 1'b0};
                ST_WA_NACK, ST_WD_NACK, ST_RA_NACK:
                    dec.nodev = 1'b1;
                default: dec = stop_fin;
            endcase
        end
    end
endmodule

// File: rtl/i2c_seq_timer.sv
module i2c_seq_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             clear,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);
    logic [TMO_W-1:0] cnt_q;

    assign expired = run && (limit != '0) && (cnt_q == limit - TMO_W'(1));

    always_ff @(posedge clk) begin
        if (rst || clear || !run)
            cnt_q <= '0;
        else if (!expired)
            cnt_q <= cnt_q + TMO_W'(1);
    end
endmodule

// File: rtl/i2c_msg_seq.sv
module i2c_msg_seq
    import i2c_seq_pkg::*;
#(
    parameter int LEN_W = 8,
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [9:0]       msg_addr,
    input  logic             msg_ten,
    input  logic             msg_read,
    input  logic             msg_nostart,
    input  logic [LEN_W-1:0] msg_len,
    input  logic [TMO_W-1:0] tmo_limit,
    input  logic [7:0]       wr_data,
    input  logic             wr_valid,
    output logic             wr_ready,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    input  logic             rd_ready,
    input  logic             core_flag,
    input  logic [7:0]       core_status,
    input  logic [7:0]       core_rdata,
    output logic [7:0]       core_wdata,
    output logic             core_data_we,
    output logic [7:0]       core_ctrl,
    output logic             core_ctrl_we,
    output logic             done,
    output logic             err_nodev,
    output logic             err_timeout
);
    seq_state_e       state_q;
    logic [LEN_W-1:0] left_q;
    logic             ack_q, ten_q, rd_q, nostart_q, kick_q;
    logic [7:0]       addr1_q, addr2_q;
    seq_dec_t         dec;
    logic             ev, need_wr, need_rd, fire, tmo_hit, is_stop, launch;

    i2c_seq_decide #(.LEN_W(LEN_W)) u_decide (
        .state(state_q), .kick(kick_q), .status(core_status), .ten(ten_q),
        .rd(rd_q), .nostart(nostart_q), .left(left_q), .dec(dec)
    );

    i2c_seq_timer #(.TMO_W(TMO_W)) u_timer (
        .clk(clk), .rst(rst),
        .run((state_q != S_IDLE) && (state_q != S_ABORT)),
        .clear(fire), .limit(tmo_limit), .expired(tmo_hit)
    );

    assign ev       = kick_q || (core_flag && !core_ctrl_we);
    assign need_wr  = (dec.act == A_DATA);
    assign need_rd  = (dec.act == A_RECV) || (dec.act == A_RECV_STOP);
    assign wr_ready = ev && need_wr;
    assign rd_valid = ev && need_rd;
    assign rd_data  = core_rdata;
    assign fire     = ev && !(need_wr && !wr_valid) && !(need_rd && !rd_ready);
    assign is_stop  = (dec.act == A_STOP) || (dec.act == A_RECV_STOP);
    assign launch   = start && (state_q == S_IDLE) && !kick_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= S_IDLE;
            left_q       <= '0;
            ack_q        <= 1'b1;
            ten_q        <= 1'b0;
            rd_q         <= 1'b0;
            nostart_q    <= 1'b0;
            kick_q       <= 1'b0;
            addr1_q      <= '0;
            addr2_q      <= '0;
            core_wdata   <= '0;
            core_data_we <= 1'b0;
            core_ctrl    <= '0;
            core_ctrl_we <= 1'b0;
            done         <= 1'b0;
            err_nodev    <= 1'b0;
            err_timeout  <= 1'b0;
        end else begin
            core_ctrl_we <= 1'b0;
            core_data_we <= 1'b0;
            done         <= 1'b0;
            if (launch) begin
                left_q      <= msg_len;
                ack_q       <= 1'b1;
                ten_q       <= msg_ten;
                rd_q        <= msg_read;
                nostart_q   <= msg_nostart;
                addr1_q     <= first_addr_byte(msg_addr, msg_ten, msg_read);
                addr2_q     <= msg_addr[7:0];
                kick_q      <= 1'b1;
                err_nodev   <= 1'b0;
                err_timeout <= 1'b0;
            end else if (fire) begin
                kick_q       <= 1'b0;
                state_q      <= dec.nxt;
                if (dec.dec)     left_q <= left_q - LEN_W'(1);
                if (dec.ack_clr) ack_q  <= 1'b0;
                core_ctrl    <= ctrl_word(ack_q & ~dec.ack_clr,
                                          dec.act == A_START, is_stop);
                core_ctrl_we <= 1'b1;
                case (dec.act)
                    A_ADDR1: begin core_wdata <= addr1_q; core_data_we <= 1'b1; end
                    A_ADDR2: begin core_wdata <= addr2_q; core_data_we <= 1'b1; end
                    A_DATA:  begin core_wdata <= wr_data; core_data_we <= 1'b1; end
                    default: ;
                endcase
                done <= dec.finish;
                if (dec.nodev) err_nodev   <= 1'b1;
                if (dec.tmo)   err_timeout <= 1'b1;
            end else if (tmo_hit) begin
                state_q <= S_ABORT;
            end
        end
    end
endmodule

// File: rtl/i2c_msg_seq_chk.sv
module i2c_msg_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] core_ctrl,
    input logic       core_ctrl_we,
    input logic       core_data_we,
    input logic       done,
    input logic       err_nodev,
    input logic       err_timeout,
    input logic       wr_ready,
    input logic       rd_valid
);
    assert_stop_drops_ie_R11: assert property (@(posedge clk) disable iff (rst)
        core_ctrl_we && core_ctrl[4] |-> !core_ctrl[7]);
    assert_run_keeps_en_R11: assert property (@(posedge clk) disable iff (rst)
        core_ctrl_we && !core_ctrl[4] |-> core_ctrl[7] && core_ctrl[6]);
    assert_no_start_with_stop_R11: assert property (@(posedge clk) disable iff (rst)
        core_ctrl_we |-> !(core_ctrl[4] && core_ctrl[5]));
    assert_done_has_stop_R4: assert property (@(posedge clk) disable iff (rst)
        done |-> core_ctrl_we && core_ctrl[4]);
    assert_data_has_ctrl_R2: assert property (@(posedge clk) disable iff (rst)
        core_data_we |-> core_ctrl_we);
    assert_nodev_at_done_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(err_nodev) |-> done);
    assert_tmo_at_done_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(err_timeout) |-> done);
    assert_streams_exclusive_R12: assert property (@(posedge clk) disable iff (rst)
        !(wr_ready && rd_valid));
endmodule

bind i2c_msg_seq i2c_msg_seq_chk chk_i (
    .clk(clk), .rst(rst), .core_ctrl(core_ctrl), .core_ctrl_we(core_ctrl_we),
    .core_data_we(core_data_we), .done(done), .err_nodev(err_nodev),
    .err_timeout(err_timeout), .wr_ready(wr_ready), .rd_valid(rd_valid)
);

// File: tb/i2c_msg_seq_tb.sv
`timescale 1ns/1ps
module i2c_msg_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [9:0] msg_addr = '0;
    logic       msg_ten = 1'b0, msg_read = 1'b0, msg_nostart = 1'b0;
    logic [7:0] msg_len = '0;
    logic [15:0] tmo_limit = '0;
    logic [7:0] wr_data = '0;
    logic       wr_valid = 1'b1;
    logic       wr_ready;
    logic [7:0] rd_data;
    logic       rd_valid;
    logic       rd_ready = 1'b1;
    logic       core_flag = 1'b0;
    logic [7:0] core_status = 8'hF8, core_rdata = '0;
    logic [7:0] core_wdata, core_ctrl;
    logic       core_data_we, core_ctrl_we, done, err_nodev, err_timeout;

    int checks = 0;
    int errors = 0;
    logic       rx_seen;
    logic [7:0] rx_byte;

    always #2.5 clk = ~clk;

    i2c_msg_seq dut_i (
        .clk(clk), .rst(rst), .start(start), .msg_addr(msg_addr), .msg_ten(msg_ten),
        .msg_read(msg_read), .msg_nostart(msg_nostart), .msg_len(msg_len),
        .tmo_limit(tmo_limit), .wr_data(wr_data), .wr_valid(wr_valid),
        .wr_ready(wr_ready), .rd_data(rd_data), .rd_valid(rd_valid),
        .rd_ready(rd_ready), .core_flag(core_flag), .core_status(core_status),
        .core_rdata(core_rdata), .core_wdata(core_wdata),
        .core_data_we(core_data_we), .core_ctrl(core_ctrl),
        .core_ctrl_we(core_ctrl_we), .done(done), .err_nodev(err_nodev),
        .err_timeout(err_timeout)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic launch(input logic [9:0] a, input logic ten, input logic rd,
                          input logic ns, input logic [7:0] len);
        @(negedge clk);
        msg_addr = a; msg_ten = ten; msg_read = rd; msg_nostart = ns; msg_len = len;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic post(input logic [7:0] st, input logic [7:0] rd);
        @(negedge clk);
        core_status = st; core_rdata = rd; core_flag = 1'b1;
        rx_seen = 1'b0;
        #1;
        if (rd_valid && rd_ready) begin rx_seen = 1'b1; rx_byte = rd_data; end
    endtask

    task automatic expect_w(input string tag, input logic [7:0] ectrl,
                            input logic edwe, input logic [7:0] ewd, input logic edone);
        int n = 0;
        while (!core_ctrl_we && n < 50) begin
            @(negedge clk);
            n++;
            if (core_ctrl_we) break;
        end
        core_flag = 1'b0;
        chk({tag, " ctrl"}, {24'b0, core_ctrl}, {24'b0, ectrl});
        chk({tag, " data_we"}, {31'b0, core_data_we}, {31'b0, edwe});
        if (edwe) chk({tag, " wdata"}, {24'b0, core_wdata}, {24'b0, ewd});
        chk({tag, " done"}, {31'b0, done}, {31'b0, edone});
    endtask

    task automatic t_reset;
        chk("R1 ctrl_we", {31'b0, core_ctrl_we}, 0);
        chk("R1 done", {31'b0, done}, 0);
        chk("R1 errs", {30'b0, err_nodev, err_timeout}, 0);
        chk("R1 streams", {30'b0, wr_ready, rd_valid}, 0);
    endtask

    task automatic t_write7;
        launch(10'h02A, 0, 0, 0, 2);
        expect_w("R11 start", 8'hE4, 0, 0, 0);
        post(8'h08, 0);  expect_w("R2 addr7 wr", 8'hC4, 1, 8'h54, 0);
        wr_data = 8'h11; post(8'h18, 0); expect_w("R4 byte0", 8'hC4, 1, 8'h11, 0);
        wr_data = 8'h22; post(8'h28, 0); expect_w("R4 byte1", 8'hC4, 1, 8'h22, 0);
        post(8'h28, 0);  expect_w("R4 stop", 8'h54, 0, 0, 1);
        chk("R4 no err", {30'b0, err_nodev, err_timeout}, 0);
    endtask

    task automatic t_read7;
        launch(10'h050, 0, 1, 0, 2);
        expect_w("R11 start rd", 8'hE4, 0, 0, 0);
        post(8'h10, 0); expect_w("R2 addr7 rd", 8'hC4, 1, 8'hA1, 0);
        post(8'h40, 0); expect_w("R5 addr ack", 8'hC4, 0, 0, 0);
        post(8'h50, 8'h3C);
        chk("R5 rx0", {23'b0, rx_seen, rx_byte}, {23'b0, 1'b1, 8'h3C});
        expect_w("R5 ack drop", 8'hC0, 0, 0, 0);
        post(8'h58, 8'h7E);
        chk("R5 rx1", {23'b0, rx_seen, rx_byte}, {23'b0, 1'b1, 8'h7E});
        expect_w("R5 stop", 8'h50, 0, 0, 1);
    endtask

    task automatic t_ten;
        launch(10'h2B5, 1, 0, 0, 1);
        expect_w("R3 start", 8'hE4, 0, 0, 0);
        post(8'h08, 0); expect_w("R3 addr1 wr", 8'hC4, 1, 8'hF4, 0);
        post(8'h18, 0); expect_w("R3 addr2 wr", 8'hC4, 1, 8'hB5, 0);
        wr_data = 8'h33; post(8'hD0, 0); expect_w("R4 after D0", 8'hC4, 1, 8'h33, 0);
        post(8'h28, 0); expect_w("R4 ten stop", 8'h54, 0, 0, 1);
        launch(10'h1C3, 1, 1, 0, 1);
        expect_w("R3 start rd", 8'hE4, 0, 0, 0);
        post(8'h08, 0); expect_w("R3 addr1 rd", 8'hC4, 1, 8'hF3, 0);
        post(8'h40, 0); expect_w("R3 addr2 rd", 8'hC4, 1, 8'hC3, 0);
        post(8'hE0, 0); expect_w("R5 single ack drop", 8'hC0, 0, 0, 0);
        post(8'h58, 8'h99);
        chk("R5 ten rx", {23'b0, rx_seen, rx_byte}, {23'b0, 1'b1, 8'h99});
        expect_w("R5 ten stop", 8'h50, 0, 0, 1);
    endtask

    task automatic t_zero_read;
        launch(10'h011, 0, 1, 0, 0);
        expect_w("R6 start", 8'hE4, 0, 0, 0);
        post(8'h08, 0); expect_w("R6 addr", 8'hC4, 1, 8'h23, 0);
        post(8'h40, 0); expect_w("R6 stop", 8'h54, 0, 0, 1);
        chk("R6 no err", {31'b0, err_nodev}, 0);
    endtask

    task automatic t_nack;
        launch(10'h012, 0, 0, 0, 1);
        expect_w("R7 start", 8'hE4, 0, 0, 0);
        post(8'h08, 0); expect_w("R7 addr", 8'hC4, 1, 8'h24, 0);
        post(8'h20, 0); expect_w("R7 addr nack", 8'h54, 0, 0, 1);
        chk("R7 nodev 0x20", {31'b0, err_nodev}, 1);
        launch(10'h012, 0, 0, 0, 1);
        expect_w("R7 start2", 8'hE4, 0, 0, 0);
        chk("R7 err cleared", {31'b0, err_nodev}, 0);
        post(8'h08, 0); expect_w("R7 addr2", 8'hC4, 1, 8'h24, 0);
        wr_data = 8'h5A; post(8'h18, 0); expect_w("R7 data", 8'hC4, 1, 8'h5A, 0);
        post(8'h30, 0); expect_w("R7 data nack", 8'h54, 0, 0, 1);
        chk("R7 nodev 0x30", {31'b0, err_nodev}, 1);
        launch(10'h012, 0, 1, 0, 1);
        expect_w("R7 start3", 8'hE4, 0, 0, 0);
        post(8'h08, 0); expect_w("R7 addr3", 8'hC4, 1, 8'h25, 0);
        post(8'h48, 0); expect_w("R7 rd addr nack", 8'h54, 0, 0, 1);
        chk("R7 nodev 0x48", {31'b0, err_nodev}, 1);
    endtask

    task automatic t_unexpected;
        launch(10'h013, 0, 0, 0, 3);
        expect_w("R8 start", 8'hE4, 0, 0, 0);
        post(8'h08, 0); expect_w("R8 addr", 8'hC4, 1, 8'h26, 0);
        post(8'hF8, 0); expect_w("R8 stop", 8'h54, 0, 0, 1);
        chk("R8 no err", {30'b0, err_nodev, err_timeout}, 0);
    endtask

    task automatic t_nostart;
        launch(10'h000, 0, 1, 1, 1);
        expect_w("R9 rd bare ctrl", 8'hC0, 0, 0, 0);
        post(8'h58, 8'h5A);
        chk("R9 rx", {23'b0, rx_seen, rx_byte}, {23'b0, 1'b1, 8'h5A});
        expect_w("R9 rd stop", 8'h50, 0, 0, 1);
        wr_data = 8'h44;
        launch(10'h000, 0, 0, 1, 1);
        expect_w("R9 wr first byte", 8'hC4, 1, 8'h44, 0);
        post(8'h28, 0); expect_w("R9 wr stop", 8'h54, 0, 0, 1);
    endtask

    task automatic t_stall;
        int seen = 0;
        launch(10'h014, 0, 0, 0, 1);
        expect_w("R12 start", 8'hE4, 0, 0, 0);
        post(8'h08, 0); expect_w("R12 addr", 8'hC4, 1, 8'h28, 0);
        wr_valid = 1'b0;
        post(8'h18, 0);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (core_ctrl_we) seen++;
        end
        chk("R12 no write while stalled", seen, 0);
        chk("R12 ready offered", {31'b0, wr_ready}, 1);
        wr_data = 8'h77; wr_valid = 1'b1;
        expect_w("R12 send after valid", 8'hC4, 1, 8'h77, 0);
        post(8'h28, 0); expect_w("R12 stop", 8'h54, 0, 0, 1);
    endtask

    task automatic t_timeout;
        tmo_limit = 16'd20;
        launch(10'h015, 0, 0, 0, 1);
        expect_w("R10 start", 8'hE4, 0, 0, 0);
        repeat (40) @(negedge clk);
        chk("R10 quiet before flag", {30'b0, done, err_timeout}, 0);
        post(8'h08, 0); expect_w("R10 abort stop", 8'h54, 0, 0, 1);
        chk("R10 tmo set", {31'b0, err_timeout}, 1);
        tmo_limit = '0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_write7;
        t_read7;
        t_ten;
        t_zero_read;
        t_nack;
        t_unexpected;
        t_nostart;
        t_stall;
        t_timeout;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #500000;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule